// File: doc/BRIEF.md
# Regularized Bit-Slice ALU with Equality-Checked Self-Test

This block is a small arithmetic and logic datapath built from identical one-bit cells. The cells are chained by a ripple carry. In normal operation it adds, subtracts, ANDs, ORs or XORs two operands and reports a carry-out. A slice control decoder turns the opcode into per-cell control. A second copy of that decoder runs beside the first so that control faults can be seen.

Raising `test_en` switches the block into a self-test arrangement. Gating on each cell input replaces the operand bits and the carry chain with one shared stimulus, so every cell receives the same inputs. Every fault-free cell then gives the same sum and carry. The stimulus comes from a 4-bit nonlinear feedback shift register that visits all 16 states. No signature register or stored golden response is needed. Cell responses are registered and compared with each other, and the two decoder copies are compared with each other. Any disagreement is held in a sticky error latch.

Top module: `bsst_datapath`

## Requirements
- R1: With the test not running and `op_sel` = 0 (add), `result_o` equals `op_a + op_b` mod 16 and `cout_o` is the carry out of bit 3.
- R2: With `op_sel` = 1 (subtract), `result_o` equals `op_a - op_b` mod 16 and `cout_o` is 1 exactly when `op_a >= op_b` (no borrow).
- R3: With `op_sel` = 2, 3 or 4, `result_o` is the bitwise AND, OR or XOR of the operands and `cout_o` is 0.
- R4: The unused opcode values 5, 6 and 7 give the same `result_o` and `cout_o` as add.
- R5: In the cycle after reset, `err_o`, both bits of `err_src_o` and `test_done_o` are 0.
- R6: The clock edge that first samples `test_en` high starts a self-test run. `test_done_o` rises on the 16th edge after that one and stays high while `test_en` stays high. It is 0 after any edge that samples `test_en` low.
- R7: A complete run on a fault-free block leaves `err_o` at 0.
- R8: If the cells disagree during a run (the sum or carry of any slice differs from slice 0), `err_src_o[0]` and `err_o` become 1.
- R9: If the two slice control decoder copies disagree at any time, `err_src_o[1]` and `err_o` become 1.
- R10: Once set, an error bit stays set through further runs, through `test_en` going low and through fault-free cycles. Only reset clears it.
- R11: During the 16 cycles of a run on a fault-free block, all bits of `result_o` are equal (0x0 or 0xF), because every slice receives the same stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Self-test request; a rising level starts a run |
| op_sel | input | 3 | Opcode: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR |
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| result_o | output | 4 | Cell sum outputs |
| cout_o | output | 1 | Carry-out of the most significant slice |
| test_done_o | output | 1 | All 16 stimulus states have been applied |
| err_o | output | 1 | OR of the sticky error bits |
| err_src_o | output | 2 | Sticky error bits: bit 0 for the datapath, bit 1 for control |

## Verification
Add and subtract are driven with every operand pair. This separates a broken carry chain, a wrong carry-in on slice 0 and a wrong borrow sense from plain sum errors. Every opcode, including the three unused ones, is run over a spread of operand values so that a decoder that maps one code to the wrong cell function shows up. The self-test is run fault-free, which shows the uniform-stimulus result and the run length. It is then run with a cell output forced to a non-uniform value and with the shadow decoder forced, which tells apart a datapath report from a control report. Both reports are then checked to survive later runs and clear only on reset.

// File: rtl/bsst_pkg.sv
package bsst_pkg;

    // Stimulus generator geometry
    localparam int          PAT_W      = 4;
    localparam int          PAT_STATES = 1 << PAT_W;
    localparam logic [PAT_W-1:0] PAT_SEED = 4'b0001;
    localparam int          CNT_W      = $clog2(PAT_STATES);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } opcode_e;

    typedef enum logic [1:0] {
        FN_SUM = 2'd0,
        FN_AND = 2'd1,
        FN_OR  = 2'd2,
        FN_XOR = 2'd3
    } cell_fn_e;

    // Control word shared by all slices
    typedef struct packed {
        logic     inv_b;
        logic     carry0;
        cell_fn_e fn;
    } slice_ctrl_t;

    // Inputs of one slice
    typedef struct packed {
        logic a;
        logic b;
        logic cin;
    } cell_stim_t;

    function automatic slice_ctrl_t decode_op(input logic [2:0] code);
        slice_ctrl_t c;
        c = '{inv_b: 1'b0, carry0: 1'b0, fn: FN_SUM};
        case (code)
            OP_SUB:  begin c.inv_b = 1'b1; c.carry0 = 1'b1; end
            OP_AND:  c.fn = FN_AND;
            OP_OR:   c.fn = FN_OR;
            OP_XOR:  c.fn = FN_XOR;
            default: c.fn = FN_SUM;
        endcase
        return c;
    endfunction

    // Shift-left LFSR (x^4 + x^3 + 1) with the all-zero state spliced in
    function automatic logic [PAT_W-1:0] pat_next(input logic [PAT_W-1:0] s);
        logic fb;
        fb = s[3] ^ s[2] ^ (s[2:0] == 3'b000);
        return {s[2:0], fb};
    endfunction

    // Opcode applied to the decoders during a run, from the run counter
    function automatic logic [2:0] run_opcode(input logic [CNT_W-1:0] cnt);
        return cnt[2] ? 3'(OP_XOR) : {1'b0, cnt[1:0]};
    endfunction

endpackage

// File: rtl/bsst_ctrl_decoder.sv
module bsst_ctrl_decoder
    import bsst_pkg::*;
(
    input  logic [2:0]  code_i,
    output slice_ctrl_t ctrl_o
);
    always_comb begin
        ctrl_o = decode_op(code_i);
    end
endmodule

// File: rtl/bsst_cell.sv
module bsst_cell
    import bsst_pkg::*;
(
    input  cell_stim_t  stim_i,
    input  slice_ctrl_t ctrl_i,
    output logic        sum_o,
    output logic        cout_o
);
    logic bx;

    always_comb begin
        bx     = stim_i.b ^ ctrl_i.inv_b;
        sum_o  = 1'b0;
        cout_o = 1'b0;
        case (ctrl_i.fn)
            FN_SUM: begin
                sum_o  = stim_i.a ^ bx ^ stim_i.cin;
                cout_o = (stim_i.a & bx) | (stim_i.a & stim_i.cin) | (bx & stim_i.cin);
            end
            FN_AND:  sum_o = stim_i.a & bx;
            FN_OR:   sum_o = stim_i.a | bx;
            FN_XOR:  sum_o = stim_i.a ^ bx;
            default: sum_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsst_pattern_gen.sv
module bsst_pattern_gen
    import bsst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en,
    output logic             run_o,
    output logic [PAT_W-1:0] pat_o,
    output logic [2:0]       op_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PAT_STATES - 1);

    logic             test_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PAT_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            test_q  <= 1'b0;
            run_o   <= 1'b0;
            done_o  <= 1'b0;
            cnt_q   <= '0;
            state_q <= PAT_SEED;
        end else begin
            test_q <= test_en;
            if (!test_en) begin
                run_o  <= 1'b0;
                done_o <= 1'b0;
            end else if (!test_q) begin
                run_o   <= 1'b1;
                done_o  <= 1'b0;
                cnt_q   <= '0;
                state_q <= PAT_SEED;
            end else if (run_o) begin
                if (cnt_q == LAST) begin
                    run_o  <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    cnt_q   <= cnt_q + 1'b1;
                    state_q <= pat_next(state_q);
                end
            end
        end
    end

    assign pat_o = state_q;
    assign op_o  = run_opcode(cnt_q);
endmodule

// File: rtl/bsst_resp_check.sv
module bsst_resp_check
    import bsst_pkg::*;
#(
    parameter int W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run_i,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] cout_i,
    input  slice_ctrl_t ctrl_main_i,
    input  slice_ctrl_t ctrl_shd_i,
    output logic [1:0]  err_src_o
);
    logic [W-1:0] sum_q;
    logic [W-1:0] cout_q;
    logic         vld_q;
    slice_ctrl_t  main_q;
    slice_ctrl_t  shd_q;
    logic         dp_miss;
    logic         ctrl_miss;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            cout_q <= '0;
            vld_q  <= 1'b0;
            main_q <= '0;
            shd_q  <= '0;
        end else begin
            sum_q  <= sum_i;
            cout_q <= cout_i;
            vld_q  <= run_i;
            main_q <= ctrl_main_i;
            shd_q  <= ctrl_shd_i;
        end
    end

    // Every captured slice must agree with slice 0
    assign dp_miss   = vld_q && ((sum_q != {W{sum_q[0]}}) || (cout_q != {W{cout_q[0]}}));
    assign ctrl_miss = (main_q != shd_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_src_o <= 2'b00;
        end else begin
            err_src_o <= err_src_o | {ctrl_miss, dp_miss};
        end
    end
endmodule

// File: rtl/bsst_datapath.sv
module bsst_datapath
    import bsst_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         test_en,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] result_o,
    output logic         cout_o,
    output logic         test_done_o,
    output logic         err_o,
    output logic [1:0]   err_src_o
);
    logic             test_run;
    logic [PAT_W-1:0] pat;
    logic [2:0]       test_op;
    logic [2:0]       dec_code;
    slice_ctrl_t      ctrl_main;
    slice_ctrl_t      ctrl_shd;
    logic [W-1:0]     cell_sum;
    logic [W-1:0]     cell_cout;

    bsst_pattern_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .run_o   (test_run),
        .pat_o   (pat),
        .op_o    (test_op),
        .done_o  (test_done_o)
    );

    assign dec_code = test_run ? test_op : op_sel;

    bsst_ctrl_decoder u_dec_main (.code_i(dec_code), .ctrl_o(ctrl_main));
    bsst_ctrl_decoder u_dec_shd  (.code_i(dec_code), .ctrl_o(ctrl_shd));

    for (genvar i = 0; i < W; i++) begin : g_slice
        cell_stim_t stim;
        logic       chain_cin;

        if (i == 0) begin : g_first
            assign chain_cin = ctrl_main.carry0;
        end else begin : g_rest
            assign chain_cin = cell_cout[i-1];
        end

        // Regularization gating: shared stimulus under test
        assign stim.a   = test_run ? pat[0] : op_a[i];
        assign stim.b   = test_run ? pat[1] : op_b[i];
        assign stim.cin = test_run ? pat[2] : chain_cin;

        bsst_cell u_cell (
            .stim_i (stim),
            .ctrl_i (ctrl_main),
            .sum_o  (cell_sum[i]),
            .cout_o (cell_cout[i])
        );
    end

    bsst_resp_check #(.W(W)) u_resp (
        .clk         (clk),
        .rst         (rst),
        .run_i       (test_run),
        .sum_i       (cell_sum),
        .cout_i      (cell_cout),
        .ctrl_main_i (ctrl_main),
        .ctrl_shd_i  (ctrl_shd),
        .err_src_o   (err_src_o)
    );

    assign result_o = cell_sum;
    assign cout_o   = cell_cout[W-1];
    assign err_o    = |err_src_o;
endmodule

// File: rtl/bsst_datapath_chk.sv
module bsst_datapath_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         test_en,
    input logic         test_run,
    input logic [2:0]   op_sel,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] result_o,
    input logic         cout_o,
    input logic         test_done_o,
    input logic         err_o,
    input logic [1:0]   err_src_o
);
    // R5
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!err_o && err_src_o == 2'b00 && !test_done_o));

    // R10
    dp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_src_o[0] |=> err_src_o[0]);

    // R10
    ctrl_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_src_o[1] |=> err_src_o[1]);

    // R6
    done_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> !test_done_o);

    // R6
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(test_done_o) |-> $past(test_en));

    // R1
    add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_run && op_sel == 3'd0) |-> ({cout_o, result_o} == ({1'b0, op_a} + {1'b0, op_b})));

    // R2
    sub_diff_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_run && op_sel == 3'd1) |-> (result_o == W'(op_a - op_b) && cout_o == (op_a >= op_b)));

    // R3
    logic_cout_chk: assert property (@(posedge clk) disable iff (rst)
        (!test_run && op_sel inside {3'd2, 3'd3, 3'd4}) |-> !cout_o);
endmodule

bind bsst_datapath bsst_datapath_chk #(.W(W)) u_bsst_chk (
    .clk         (clk),
    .rst         (rst),
    .test_en     (test_en),
    .test_run    (test_run),
    .op_sel      (op_sel),
    .op_a        (op_a),
    .op_b        (op_b),
    .result_o    (result_o),
    .cout_o      (cout_o),
    .test_done_o (test_done_o),
    .err_o       (err_o),
    .err_src_o   (err_src_o)
);

// File: tb/bsst_datapath_bench.sv
module bsst_datapath_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         test_en = 1'b0;
    logic [2:0]   op_sel = 3'd0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result_o;
    logic         cout_o;
    logic         test_done_o;
    logic         err_o;
    logic [1:0]   err_src_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bsst_datapath #(.W(W)) u_bsst_datapath (
        .clk         (clk),
        .rst         (rst),
        .test_en     (test_en),
        .op_sel      (op_sel),
        .op_a        (op_a),
        .op_b        (op_b),
        .result_o    (result_o),
        .cout_o      (cout_o),
        .test_done_o (test_done_o),
        .err_o       (err_o),
        .err_src_o   (err_src_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        test_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R5: state right after reset
        check("R5 err_o", int'(err_o), 0);
        check("R5 err_src_o", int'(err_src_o), 0);
        check("R5 test_done_o", int'(test_done_o), 0);
    endtask

    task automatic apply(input logic [2:0] op, input int a, input int b);
        @(negedge clk);
        op_sel = op;
        op_a = W'(a);
        op_b = W'(b);
        #1;
    endtask

    task automatic t_add();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(3'd0, a, b);
                check("R1 add", int'({cout_o, result_o}), a + b);
            end
        end
    endtask

    task automatic t_sub();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply(3'd1, a, b);
                check("R2 sub result", int'(result_o), (a - b) & 15);
                check("R2 sub no-borrow", int'(cout_o), (a >= b) ? 1 : 0);
            end
        end
    endtask

    task automatic t_logic();
        for (int a = 0; a < 16; a += 3) begin
            for (int b = 0; b < 16; b += 5) begin
                apply(3'd2, a, b);
                check("R3 and", int'({cout_o, result_o}), a & b);
                apply(3'd3, a, b);
                check("R3 or", int'({cout_o, result_o}), a | b);
                apply(3'd4, a, b);
                check("R3 xor", int'({cout_o, result_o}), a ^ b);
            end
        end
    endtask

    task automatic t_unused();
        for (int op = 5; op < 8; op++) begin
            for (int a = 1; a < 16; a += 4) begin
                apply(3'(op), a, 15 - a + op);
                check("R4 unused as add", int'({cout_o, result_o}), a + ((15 - a + op) & 15));
            end
        end
    endtask

    // Fault-free run: uniform result, done timing, no error
    task automatic t_clean_run();
        int r;
        apply(3'd0, 0, 0);
        test_en = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            if (k <= 16) begin
                check("R6 done low during run", int'(test_done_o), 0);
                r = int'(result_o);
                check("R11 uniform slices", (r == 0 || r == 15) ? 1 : 0, 1);
            end else begin
                check("R6 done after 16 edges", int'(test_done_o), 1);
            end
        end
        repeat (3) @(negedge clk);
        check("R6 done held", int'(test_done_o), 1);
        check("R7 no error", int'(err_o), 0);
        test_en = 1'b0;
        @(negedge clk);
        check("R6 done cleared", int'(test_done_o), 0);
    endtask

    task automatic t_dp_fault();
        apply(3'd0, 0, 0);
        test_en = 1'b1;
        @(negedge clk);
        force u_bsst_datapath.cell_sum = 4'b0100;
        repeat (4) @(negedge clk);
        release u_bsst_datapath.cell_sum;
        repeat (16) @(negedge clk);
        check("R8 datapath error bits", int'(err_src_o), 1);
        check("R8 err_o", int'(err_o), 1);
        test_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 held after test_en low", int'(err_src_o), 1);
        test_en = 1'b1;
        repeat (20) @(negedge clk);
        check("R10 held through clean run", int'(err_src_o), 1);
        test_en = 1'b0;
        do_reset();
        check("R10 cleared by reset", int'(err_o), 0);
    endtask

    task automatic t_ctrl_fault();
        apply(3'd3, 5, 9);
        force u_bsst_datapath.ctrl_shd = 4'hF;
        repeat (3) @(negedge clk);
        release u_bsst_datapath.ctrl_shd;
        repeat (2) @(negedge clk);
        check("R9 control error bits", int'(err_src_o), 2);
        check("R9 err_o", int'(err_o), 1);
        check("R9 datapath unaffected", int'(result_o), 5 | 9);
        repeat (4) @(negedge clk);
        check("R10 control bit held", int'(err_src_o), 2);
        do_reset();
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_add();
        t_sub();
        t_logic();
        t_unused();
        t_clean_run();
        t_dp_fault();
        t_ctrl_fault();
        t_clean_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule